// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches software with a 7-bit down-counter that must be reloaded inside an allowed window. A fixed prescaler divides the core clock. Each time the prescaler wraps, the counter steps down by one. A system-reset request is raised in three cases. The first is when the counter falls out of its upper half (bit 6 clears as it steps from 0x40 to 0x3F). The second is when software reloads it too early, while it still sits above a programmed window value. The third is when software loads it with bit 6 already clear.

Software reaches two byte-wide registers through a plain write strobe, a one-bit address and a combinational read port. The control register (address 0) holds the sticky enable in bit 7 and the counter in bits 6:0. The window register (address 1) holds the window limit in bits 6:0. A strap input can force the watchdog on whatever the enable bit holds. The block raises no interrupts. Its only output besides read data is a one-cycle reset request, which goes to the chip's reset controller.

Top module: `wwd_top`

## Requirements
- R1: After reset, address 0 reads 0x7F (enable clear, counter 0x7F), address 1 reads 0x7F, and no reset request is raised.
- R2: A write to address 1 stores data bits 6:0 as the window limit. Bit 7 of address 1 always reads 0, and writes to it are dropped.
- R3: A write to address 0 with data bit 7 high sets the enable. A write with bit 7 low leaves it set. Only the block reset clears it.
- R4: With no write to address 0, the counter drops by one every PRESCALE cycles, wrapping from 0x00 to 0x7F. The first step comes PRESCALE clock edges after reset release.
- R5: When the watchdog is active and the counter steps from 0x40 to 0x3F, a reset request is raised.
- R6: While the enable bit is clear, the strap is low and no write sets the enable, no reset request is raised.
- R7: A write to address 0 while the watchdog is active and the counter is above the window limit raises a reset request. A write with the counter at or below the limit does not.
- R8: A write to address 0 whose data bit 6 is 0 raises a reset request if the watchdog is active after that write.
- R9: The reset request goes high in the cycle after the clock edge that caught the violation. It never stays high for two cycles in a row.
- R10: With the strap input high, the watchdog is active regardless of the enable bit, and bit 7 of address 0 reads 1.
- R11: Every write to address 0 restarts the prescaler, so the next counter step comes a full PRESCALE cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous block reset |
| force_on | input | 1 | Strap: keeps the watchdog permanently active |
| bus_wr | input | 1 | Register write strobe, one write per cycle high |
| bus_addr | input | 1 | Register select: 0 control, 1 window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register that bus_addr selects (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Directed sequences first cover the cases that separate the three causes of a violation. These are a reload above the window, a reload with bit 6 clear, and an unrefreshed countdown through 0x40, each tried with the watchdog enabled, disabled and strapped on. An idle countdown with nothing enabled shows that the counter still runs but never fires. Back-to-back violating writes tell the pulse shaper apart from a plain register. A refresh in the middle of a prescaler period tells a restarting prescaler from a free-running one. Constrained-random write streams then mix window changes, reloads, strap toggles and resets. These catch mistakes in how a write and a tick interact in the same cycle.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_WIN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int unsigned PRESCALE = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] div_q;

  // A restart in the same cycle pre-empts the wrap
  assign tick = (div_q == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart || (div_q == LAST)) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             win_wr,
  input  logic [CNT_W:0]   wdata,
  input  logic             tick,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] win_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '1;
      win_q <= '1;
    end else begin
      // enable is set-only
      if (ctrl_wr && wdata[CNT_W]) en_q <= 1'b1;
      if (ctrl_wr) begin
        cnt_q <= wdata[CNT_W-1:0];
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (win_wr) win_q <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wwd_judge.sv
module wwd_judge #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             en_q,
  input  logic             force_on,
  input  logic             ctrl_wr,
  input  logic [CNT_W:0]   wdata,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] win_q,
  output logic             violation
);
  localparam logic [CNT_W-1:0] MIDPOINT = {1'b1, {(CNT_W-1){1'b0}}};

  logic active_now, active_after, early, low_load, expire;

  assign active_now   = en_q | force_on;
  assign active_after = active_now | wdata[CNT_W];
  assign early        = ctrl_wr & active_now & (cnt_q > win_q);
  assign low_load     = ctrl_wr & active_after & ~wdata[CNT_W-1];
  assign expire       = tick & active_now & (cnt_q == MIDPOINT);
  assign violation    = early | low_load | expire;
endmodule

// File: rtl/wwd_pulse.sv
module wwd_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic violation,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= violation & ~rst_req;
    end
  end
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int unsigned PRESCALE = 12288,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_on,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [CNT_W:0]   bus_wdata,
  output logic [CNT_W:0]   bus_rdata,
  output logic             rst_req
);
  reg_sel_e         sel;
  logic             ctrl_wr, win_wr, tick, en_q, violation;
  logic [CNT_W-1:0] cnt_q, win_q;

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_wr = bus_wr && (sel == REG_CTRL);
  assign win_wr  = bus_wr && (sel == REG_WIN);

  wwd_prescaler #(.PRESCALE(PRESCALE)) u_psc (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .tick(tick)
  );

  wwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .win_wr(win_wr),
    .wdata(bus_wdata), .tick(tick), .en_q(en_q), .cnt_q(cnt_q), .win_q(win_q)
  );

  wwd_judge #(.CNT_W(CNT_W)) u_judge (
    .en_q(en_q), .force_on(force_on), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .tick(tick), .cnt_q(cnt_q), .win_q(win_q), .violation(violation)
  );

  wwd_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .violation(violation), .rst_req(rst_req)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = {en_q | force_on, cnt_q};
      REG_WIN:  bus_rdata = {1'b0, win_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             force_on,
  input logic             ctrl_wr,
  input logic             wdata_msb,
  input logic             tick,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rd_win,
  input logic             rdata_msb,
  input logic             rst_req
);
  localparam logic [CNT_W-1:0] MIDPOINT = {1'b1, {(CNT_W-1){1'b0}}};

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R3

  AST_QUIET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !force_on && !(ctrl_wr && wdata_msb)) |=> !rst_req); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && tick) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !tick) |=> $stable(cnt_q)); // R4

  AST_EXPIRE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && (en_q || force_on) && (cnt_q == MIDPOINT) && !rst_req)
      |=> rst_req); // R5

  AST_WIN_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win |-> !rdata_msb); // R2

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !tick); // R11
endmodule

bind wwd_top wwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_on(force_on), .ctrl_wr(ctrl_wr),
  .wdata_msb(bus_wdata[CNT_W]), .tick(tick), .en_q(en_q), .cnt_q(cnt_q),
  .rd_win(bus_addr), .rdata_msb(bus_rdata[CNT_W]), .rst_req(rst_req)
);

// File: tb/wwd_top_test.sv
`timescale 1ns/1ps
module wwd_top_test;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       force_on = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_req;

  always #10 clk = ~clk;

  wwd_top #(.PRESCALE(P), .CNT_W(7)) uut (
    .clk(clk), .rst_n(rst_n), .force_on(force_on), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       m_en, m_req;
  bit [6:0] m_cnt, m_win;
  int       m_psc;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] exp_rd(bit a);
    return a ? {1'b0, m_win} : {m_en | force_on, m_cnt};
  endfunction

  task automatic model_reset();
    m_en = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_psc = 0; m_req = 0;
  endtask

  task automatic model_edge(bit wr, bit a, bit [7:0] d);
    bit act, ev;
    act = m_en | force_on;
    ev  = 0;
    if (wr && !a) begin
      if (act && (m_cnt > m_win)) ev = 1;
      if ((act | d[7]) && !d[6]) ev = 1;
      m_en  = m_en | d[7];
      m_cnt = d[6:0];
      m_psc = 0;
    end else begin
      if (wr && a) m_win = d[6:0];
      if (m_psc == P - 1) begin
        m_psc = 0;
        if (act && (m_cnt == 7'h40)) ev = 1;
        m_cnt = m_cnt - 7'd1;
      end else begin
        m_psc++;
      end
    end
    m_req = ev & ~m_req;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(bit wr, bit a, bit [7:0] d, string req);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(wr, a, d);
    @(negedge clk);
    bus_wr = 0;
    check(req, rst_req, m_req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cycle(0, 0, 8'h00, req);
  endtask

  task automatic rd(bit a, string req);
    bus_wr = 0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp_rd(a));
  endtask

  task automatic do_reset();
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R1 reset values
    bus_addr = 0; #1 check("R1", bus_rdata, 8'h7F);
    bus_addr = 1; #1 check("R1", bus_rdata, 8'h7F);
    check("R1", rst_req, 1'b0);

    // R2 window bit 7 dropped
    cycle(1, 1, 8'hD5, "R2");
    bus_addr = 1; #1 check("R2", bus_rdata, 8'h55);

    // R4 first step timing and wrap
    do_reset();
    idle(P - 1, "R4");
    bus_addr = 0; #1 check("R4", bus_rdata, 8'h7F);
    idle(1, "R4");
    bus_addr = 0; #1 check("R4", bus_rdata, 8'h7E);
    cycle(1, 0, 8'h40, "R4");
    idle(P, "R4");
    bus_addr = 0; #1 check("R6", {31'd0, rst_req}, 0);
    cycle(1, 1, 8'h00, "R4");
    cycle(1, 0, 8'h80 | 8'h40, "R4");
    do_reset();
    cycle(1, 0, 8'h00, "R6");   // low load while inactive: no request
    idle(P, "R4");
    rd(0, "R4");
    bus_addr = 0; #1 check("R4", bus_rdata, 8'h7F);

    // R6 inactive countdown through 0x40
    cycle(1, 0, 8'h41, "R6");
    idle(3 * P, "R6");
    rd(0, "R6");

    // R11 refresh restarts prescaler
    cycle(1, 0, 8'h50, "R11");
    idle(P / 2, "R11");
    cycle(1, 0, 8'h50, "R11");
    idle(P - 1, "R11");
    bus_addr = 0; #1 check("R11", bus_rdata, 8'h50);
    idle(1, "R11");
    bus_addr = 0; #1 check("R11", bus_rdata, 8'h4F);

    // R3 sticky enable
    do_reset();
    cycle(1, 0, 8'hFF, "R3");
    bus_addr = 0; #1 check("R3", bus_rdata[7], 1'b1);
    cycle(1, 0, 8'h7F, "R3");
    bus_addr = 0; #1 check("R3", bus_rdata[7], 1'b1);

    // R5 / R9 expiry pulse timing
    cycle(1, 0, 8'h41, "R5");
    idle(2 * P - 1, "R5");
    check("R5", rst_req, 1'b0);
    idle(1, "R5");
    check("R5", rst_req, 1'b1);
    idle(1, "R9");
    check("R9", rst_req, 1'b0);

    // R7 early refresh
    do_reset();
    cycle(1, 1, 8'h50, "R7");
    cycle(1, 0, 8'hFF, "R7");
    check("R7", rst_req, 1'b0);
    cycle(1, 0, 8'h7F, "R7");
    check("R7", rst_req, 1'b1);
    cycle(1, 1, 8'h7F, "R7");
    cycle(1, 0, 8'h60, "R7");
    check("R7", rst_req, 1'b0);

    // R8 low load while active
    cycle(1, 0, 8'h3A, "R8");
    check("R8", rst_req, 1'b1);
    idle(1, "R8");

    // R9 back-to-back violations still give one-cycle pulses
    cycle(1, 0, 8'h30, "R9");
    check("R9", rst_req, 1'b1);
    cycle(1, 0, 8'h30, "R9");
    check("R9", rst_req, 1'b0);

    // R10 strap forces activity
    do_reset();
    force_on = 1;
    bus_addr = 0; #1 check("R10", bus_rdata, 8'hFF);
    cycle(1, 0, 8'h41, "R10");
    idle(2 * P - 1, "R10");
    idle(1, "R10");
    check("R10", rst_req, 1'b1);
    cycle(1, 1, 8'h20, "R10");
    cycle(1, 0, 8'h7F, "R10");
    check("R10", rst_req, 1'b1);
    force_on = 0;

    // constrained random traffic against the model
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      int r;
      bit a;
      bit [7:0] d;
      r = $urandom % 100;
      a = $urandom % 2;
      d = 8'($urandom);
      if (!a && ($urandom % 2)) d[6] = 1'b1;
      if ($urandom % 700 == 0) force_on = ~force_on;
      if ($urandom % 2500 == 0) do_reset();
      cycle(r < 4, a, d, "R5");
      if (n % 7 == 0) begin
        rd(0, "R4");
        rd(1, "R2");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule